// File: doc/BRIEF.md
# Port Interrupt Status and Online Controller

This block holds the status and control registers of one storage port. Pulses from the command and link logic set sticky event bits. Nine fatal-cause inputs are latched as well, and any of them raises a summary fatal event. Per-event enable bits in the control register gate the events onto one level-sensitive interrupt line. Software acknowledges an event by writing ones to its bits.

The control register also sequences the port online and offline. Setting the online request releases the PHY reset. The port is then reported online once the PHY signals ready. Coming online posts a PHY-ready-change event, and a signature-update event follows one cycle later. A force-offline bit holds the PHY in reset, raises an abort line to the command logic, and takes the port offline on the next clock edge.

Access goes through a simple single-cycle register port. Address 0 selects status and address 1 selects control. Reads are combinational and writes take effect at the clock edge.

Top module: `port_irq_ctl`

## Requirements
- R1: Event inputs set sticky status bits at the next clock edge: command done bit 0, device error bit 1, notification bit 2, signature bit 3. An event that arrives in the same cycle as a write-one-to-clear of its bit is kept.
- R2: Writing ones to status bits 0 to 4 clears those bits. Zero bits in the write data leave the matching status bits unchanged.
- R3: Control bits 0 to 5 enable status bits 0 to 5. The irq output is high exactly when an enabled status bit is set, with no extra delay after the status bit.
- R4: Fatal cause inputs fatal_in[5:0] set sticky status bits 13:8, and fatal_in[8:6] set sticky status bits 18:16. Each of these bits is cleared by writing a one to it.
- R5: Status bit 5 (fatal event) is high exactly while any fatal cause bit is set. Writing a one to bit 5 alone has no effect.
- R6: Control bit 31 requests online and control bit 30 forces offline. phy_rst_n is high only while bit 31 is 1 and bit 30 is 0. cmd_abort follows bit 30.
- R7: Status bit 31 (online) rises at a clock edge where phy_ready is high, the online request is set and force-offline is clear. It never rises otherwise.
- R8: The edge that raises online also sets status bit 4 (PHY-ready change). The next edge sets bit 3 (signature update), so status bits 7:0 read 0x10 and then 0x18.
- R9: Online drops one clock edge after the request is cleared or force-offline is set. Status bit 30 (going offline) is high while the port is online and an offline condition is pending.
- R10: bist_fail sets sticky status bit 29, which is cleared by writing a one to it.
- R11: After reset, status and control read 0, and irq, phy_rst_n and cmd_abort are 0.
- R12: The control register reads back only bits 31, 30 and 5:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ev_cmd_done | input | 1 | Command complete pulse |
| ev_dev_err | input | 1 | Single device error pulse |
| ev_notify | input | 1 | Notification update pulse |
| ev_sig | input | 1 | Signature update pulse |
| fatal_in | input | 9 | Fatal cause pulses |
| bist_fail | input | 1 | Self-test error pulse |
| phy_ready | input | 1 | PHY link ready |
| phy_rst_n | output | 1 | PHY reset release |
| cmd_abort | output | 1 | Abort current operations |
| irq | output | 1 | Interrupt request |

## Verification
Event pulses, fatal causes and register writes all become visible one edge after they are driven. irq shows the same delay, because it decodes the registered status without a further stage. Online rises one edge after phy_ready is seen, and the signature bit follows one edge after that. After an offline request, online falls one edge later, so the going-offline bit is visible for exactly one cycle. The bench drives its stimulus on falling edges and samples after the next falling edge. Each result is therefore read in the first cycle it is due, and, for the online sequence and the offline drop, read again one cycle later to show the staged change.

// File: rtl/port_irq_ctl.sv
module port_irq_ctl #(
  parameter int NCAUSE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_cmd_done,
  input  logic              ev_dev_err,
  input  logic              ev_notify,
  input  logic              ev_sig,
  input  logic [NCAUSE-1:0] fatal_in,
  input  logic              bist_fail,
  input  logic              phy_ready,
  output logic              phy_rst_n,
  output logic              cmd_abort,
  output logic              irq
);
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTL  = 1'b1;

  logic [4:0]        evt_q;
  logic [NCAUSE-1:0] cause_q;
  logic [5:0]        en_q;
  logic              ctl_on_q, ctl_off_q;
  logic              bist_q, online_q, sig_pend_q;

  logic [31:0] stat, ctl, wclr;
  logic [4:0]  evt_set;
  logic        fatal_evt, offline_req, online_up, sig_fire, going_off;

  assign wclr        = (reg_wr && reg_addr == ADDR_STAT) ? reg_wdata : 32'h0;
  assign offline_req = ~ctl_on_q | ctl_off_q;
  assign online_up   = ~offline_req & phy_ready & ~online_q;
  assign sig_fire    = sig_pend_q & ~offline_req;
  assign going_off   = online_q & offline_req;
  assign fatal_evt   = |cause_q;
  assign evt_set     = {online_up, ev_sig | sig_fire, ev_notify, ev_dev_err, ev_cmd_done};

  assign stat = {online_q, going_off, bist_q, 10'b0, cause_q[8:6], 2'b0,
                 cause_q[5:0], 2'b0, fatal_evt, evt_q};
  assign ctl  = {ctl_on_q, ctl_off_q, 24'b0, en_q};

  assign reg_rdata = (reg_addr == ADDR_CTL) ? ctl : stat;
  assign irq       = |(stat[5:0] & en_q);
  assign phy_rst_n = ~offline_req;
  assign cmd_abort = ctl_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q      <= '0;
      cause_q    <= '0;
      en_q       <= '0;
      ctl_on_q   <= 1'b0;
      ctl_off_q  <= 1'b0;
      bist_q     <= 1'b0;
      online_q   <= 1'b0;
      sig_pend_q <= 1'b0;
    end else begin
      evt_q      <= evt_set | (evt_q & ~wclr[4:0]);
      cause_q    <= fatal_in | (cause_q & ~{wclr[18:16], wclr[13:8]});
      bist_q     <= bist_fail | (bist_q & ~wclr[29]);
      online_q   <= ~offline_req & (online_q | phy_ready);
      sig_pend_q <= online_up;
      if (reg_wr && reg_addr == ADDR_CTL) begin
        en_q      <= reg_wdata[5:0];
        ctl_off_q <= reg_wdata[30];
        ctl_on_q  <= reg_wdata[31];
      end
    end
  end
endmodule

module port_irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_cmd_done,
  input logic [8:0]  fatal_in,
  input logic        phy_ready,
  input logic [31:0] stat,
  input logic [31:0] ctl
);
  a_r1_cmd_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_done |=> stat[0]);
  a_r5_fatal_follows_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|fatal_in) |=> stat[5]);
  a_r7_online_needs_phy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[31]) |-> ($past(phy_ready) && $past(ctl[31]) && !$past(ctl[30])));
  a_r8_phy_change_on_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[31]) |-> stat[4]);
  a_r9_offline_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[31] && (!ctl[31] || ctl[30])) |=> !stat[31]);
endmodule

bind port_irq_ctl port_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_cmd_done(ev_cmd_done), .fatal_in(fatal_in),
  .phy_ready(phy_ready), .stat(stat), .ctl(ctl)
);

// File: tb/tb_port_irq_ctl.sv
module tb_port_irq_ctl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_cmd_done = 0, ev_dev_err = 0, ev_notify = 0, ev_sig = 0;
  logic [8:0] fatal_in = 0;
  logic bist_fail = 0, phy_ready = 0;
  logic phy_rst_n, cmd_abort, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_irq_ctl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R11 status", v, 0);
    rd(1, v); chk("R11 control", v, 0);
    chk("R11 outputs", {irq, phy_rst_n, cmd_abort}, 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    @(negedge clk); ev_cmd_done = 1; ev_notify = 1;
    @(negedge clk); ev_cmd_done = 0; ev_notify = 0;
    rd(0, v); chk("R1 cmd+notify", v, 32'h5);
    @(negedge clk); ev_dev_err = 1; ev_sig = 1;
    @(negedge clk); ev_dev_err = 0; ev_sig = 0;
    rd(0, v); chk("R1 err+sig", v, 32'hF);
    wr(0, 32'h5);
    rd(0, v); chk("R2 partial clear", v, 32'hA);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1; ev_cmd_done = 1;
    @(negedge clk); reg_wr = 0; ev_cmd_done = 0;
    rd(0, v); chk("R1 set beats clear", v, 32'hB);
    wr(0, 32'h1F);
    rd(0, v); chk("R2 clear all", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 32'h2);
    @(negedge clk); ev_cmd_done = 1;
    @(negedge clk); ev_cmd_done = 0;
    chk("R3 masked event", irq, 0);
    @(negedge clk); ev_dev_err = 1;
    @(negedge clk); ev_dev_err = 0;
    chk("R3 enabled event", irq, 1);
    wr(0, 32'h2);
    chk("R3 cleared", irq, 0);
    rd(0, v); chk("R2 other bit kept", v, 32'h1);
    wr(0, 32'h1);
    wr(1, 32'h0);
  endtask

  task automatic t_fatal();
    logic [31:0] v;
    wr(1, 32'h20);
    @(negedge clk); fatal_in = 9'b1_0000_0001;
    @(negedge clk); fatal_in = 0;
    rd(0, v); chk("R4 causes latched", v, 32'h0004_0120);
    chk("R3 fatal irq", irq, 1);
    wr(0, 32'h20);
    rd(0, v); chk("R5 bit5 write ignored", v, 32'h0004_0120);
    wr(0, 32'h100);
    rd(0, v); chk("R5 held by remaining cause", v, 32'h0004_0020);
    @(negedge clk); fatal_in = 9'b0_0010_0000;
    @(negedge clk); fatal_in = 0;
    rd(0, v); chk("R4 cause 5 -> bit13", v, 32'h0004_2020);
    wr(0, 32'h0004_2000);
    rd(0, v); chk("R5 clears with causes", v, 0);
    chk("R3 irq drops", irq, 0);
    wr(1, 32'h0);
  endtask

  task automatic t_bist();
    logic [31:0] v;
    @(negedge clk); bist_fail = 1;
    @(negedge clk); bist_fail = 0;
    rd(0, v); chk("R10 bist set", v, 32'h2000_0000);
    wr(0, 32'h2000_0000);
    rd(0, v); chk("R10 bist clear", v, 0);
  endtask

  task automatic t_ctl();
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R12 readback mask", v, 32'hC000_003F);
    chk("R6 force holds reset", {phy_rst_n, cmd_abort}, 2'b01);
    wr(1, 32'h0);
  endtask

  task automatic t_online();
    logic [31:0] v;
    phy_ready = 0;
    wr(1, 32'h8000_0010);
    chk("R6 reset released", {phy_rst_n, cmd_abort}, 2'b10);
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R7 no ready no online", v, 0);
    phy_ready = 1;
    @(negedge clk);
    rd(0, v); chk("R8 phy change first", v & 32'hC000_00FF, 32'h8000_0010);
    chk("R3 phy change irq", irq, 1);
    @(negedge clk);
    rd(0, v); chk("R8 signature next", v & 32'hC000_00FF, 32'h8000_0018);
    wr(0, 32'h18);
    wr(1, 32'hC000_0000);
    rd(0, v); chk("R9 going offline", v & 32'hC000_0000, 32'hC000_0000);
    chk("R6 abort+reset", {phy_rst_n, cmd_abort}, 2'b01);
    @(negedge clk);
    rd(0, v); chk("R9 offline after force", v & 32'hC000_0000, 0);
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R7 force blocks online", v & 32'h8000_0000, 0);
    wr(1, 32'h8000_0000);
    rd(0, v); chk("R7 one edge after request", v & 32'h8000_0000, 0);
    @(negedge clk);
    rd(0, v); chk("R7 online with ready", v & 32'h8000_0000, 32'h8000_0000);
    wr(1, 32'h0);
    rd(0, v); chk("R9 going on request drop", v & 32'hC000_0000, 32'hC000_0000);
    @(negedge clk);
    rd(0, v); chk("R9 offline after drop", v & 32'hC000_0000, 0);
    phy_ready = 0;
    wr(0, 32'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_irq();
    t_fatal();
    t_bist();
    t_ctl();
    t_online();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule